// File: doc/BRIEF.md
# Keyed Control-Register Lock

This block stands in front of a memory controller's control register and keeps it from being changed by accident. A small register bus (write strobe, read strobe, word address, 32-bit data) reaches three locations: the control word, a main key port and an option key port. The control word holds two lock bits and thirty general control bits, and the block drives those control bits out to the logic it protects.

After reset both locks are set. Software clears the main lock by writing a fixed pair of 32-bit keys, in order, to the main key port. The option lock sits inside the main lock. It can only be cleared while the main lock is already clear, and it uses its own key pair on its own port. Setting the main lock through the control word sets both locks again. Any misuse of a key port raises a sticky lockout that blocks further unlocking until reset. Misuse means a wrong value, a wrong order, a key written while that lock is already clear, or an option key written while the main lock is set.

Top module: `reg_keylock`

## Requirements
- R1: After reset, mainLocked and optLocked are 1, lockout and accessErr are 0, ctrlBits is 0. A read of the control word returns 0xC000_0000.
- R2: The main lock clears only after 0x45670123 and then 0xCDEF89AB are written to the main key port (address 1). After the first key alone it is still set.
- R3: The option lock clears after 0x08192A3B and then 0x4C5D6E7F are written to the option key port (address 2), only while the main lock is clear. An option key write while the main lock is set raises lockout. The option lock is never clear while the main lock is set.
- R4: A wrong key value, or the second key written first, raises lockout. Lockout stays set until reset, and while it is set correct key pairs have no effect.
- R5: A key write to a port whose lock is already clear raises lockout and leaves the locks unchanged.
- R6: A control-word write with bit 31 set sets both locks. Bit 30 set sets only the option lock. Writing 0 to either lock bit never clears it.
- R7: While the main lock is set, a control-word write leaves ctrlBits unchanged. If any of its bits 29:0 is 1, accessErr is high for exactly the next cycle.
- R8: While the main lock is clear, a control-word write loads bits 29:0 into ctrlBits and raises no error.
- R9: Reads return data on rdData one cycle after rdEn. The control word (address 0) reads as {mainLocked, optLocked, ctrlBits}. Both key ports read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 4 | Word address: 0 control, 1 main key, 2 option key |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| ctrlBits | output | 30 | Control bits delivered to the protected logic |
| mainLocked | output | 1 | Main lock state (control bit 31) |
| optLocked | output | 1 | Option lock state (control bit 30) |
| lockout | output | 1 | Sticky key-misuse flag |
| accessErr | output | 1 | One-cycle pulse on a dropped control write |

## Verification
The bench probes the key sequencer's edges. It writes a correct first key followed by a wrong second key, and it writes the second key first. A design that only compared the last value, or accepted either order, would unlock there. It also replays correct pairs after a lockout, where a lockout that was not sticky would let the unlock through. It writes keys to locks that are already clear and option keys while the main lock is set, where a lax design would re-arm or unlock instead of locking out. On the control side it checks that clearing writes of 0 to the lock bits do nothing, that relocking also sets the option lock, and that data written while locked never reaches ctrlBits and raises an error pulse. It also checks that key ports read back zero rather than the last key.

// File: rtl/reg_keylock_pkg.sv
package reg_keylock_pkg;
  localparam int DATA_W    = 32;
  localparam int MAIN_BIT  = 31;
  localparam int OPT_BIT   = 30;
  localparam int CTRL_BITS = OPT_BIT;

  localparam logic [DATA_W-1:0] MAIN_KEY_A = 32'h4567_0123;
  localparam logic [DATA_W-1:0] MAIN_KEY_B = 32'hCDEF_89AB;
  localparam logic [DATA_W-1:0] OPT_KEY_A  = 32'h0819_2A3B;
  localparam logic [DATA_W-1:0] OPT_KEY_B  = 32'h4C5D_6E7F;

  typedef enum logic {SEQ_IDLE, SEQ_HALF} seqState_t;

  typedef struct packed {
    logic loadBits;
    logic rdCtrl;
    logic rdAny;
  } dpStrobe_t;
endpackage

// File: rtl/reg_keylock_seq.sv
module reg_keylock_seq
  import reg_keylock_pkg::*;
#(
  parameter logic [DATA_W-1:0] FIRST_KEY  = MAIN_KEY_A,
  parameter logic [DATA_W-1:0] SECOND_KEY = MAIN_KEY_B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keyWr,
  input  logic [DATA_W-1:0] keyData,
  input  logic              permit,
  input  logic              abort,
  output logic              unlockHit,
  output logic              misuse
);
  seqState_t seqQ, seqNxt;

  always_comb begin
    seqNxt    = seqQ;
    unlockHit = 1'b0;
    misuse    = 1'b0;
    if (abort) seqNxt = SEQ_IDLE;
    if (keyWr) begin
      if (!permit) begin
        misuse = 1'b1;
      end else if (seqQ == SEQ_IDLE) begin
        if (keyData == FIRST_KEY) seqNxt = SEQ_HALF;
        else                      misuse = 1'b1;
      end else begin
        if (keyData == SECOND_KEY) unlockHit = 1'b1;
        else                       misuse    = 1'b1;
        seqNxt = SEQ_IDLE;
      end
    end
    if (misuse) seqNxt = SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seqQ <= SEQ_IDLE;
    else        seqQ <= seqNxt;
  end
endmodule

// File: rtl/reg_keylock_ctrl.sv
module reg_keylock_ctrl
  import reg_keylock_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] MKEY_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] OKEY_ADDR = 'h2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic              mainLocked,
  output logic              optLocked,
  output logic              lockout,
  output logic              accessErr,
  output dpStrobe_t         strobe
);
  logic isCtrl, isMkey, isOkey;
  logic ctrlWr, relockMain, relockOpt;
  logic mainHit, mainMisuse, optHit, optMisuse;
  logic mainNxt, optNxt, lockoutNxt, errNxt;

  assign isCtrl = (addr == CTRL_ADDR);
  assign isMkey = (addr == MKEY_ADDR);
  assign isOkey = (addr == OKEY_ADDR);

  assign ctrlWr     = wrEn && isCtrl;
  assign relockMain = ctrlWr && wrData[MAIN_BIT];
  assign relockOpt  = ctrlWr && wrData[OPT_BIT];

  reg_keylock_seq #(.FIRST_KEY(MAIN_KEY_A), .SECOND_KEY(MAIN_KEY_B)) u_mainSeq (
    .clk      (clk),
    .rst_n    (rst_n),
    .keyWr    (wrEn && isMkey && !lockout),
    .keyData  (wrData),
    .permit   (mainLocked),
    .abort    (1'b0),
    .unlockHit(mainHit),
    .misuse   (mainMisuse)
  );

  reg_keylock_seq #(.FIRST_KEY(OPT_KEY_A), .SECOND_KEY(OPT_KEY_B)) u_optSeq (
    .clk      (clk),
    .rst_n    (rst_n),
    .keyWr    (wrEn && isOkey && !lockout),
    .keyData  (wrData),
    .permit   (!mainLocked && optLocked),
    .abort    (relockMain),
    .unlockHit(optHit),
    .misuse   (optMisuse)
  );

  always_comb begin
    mainNxt    = mainLocked;
    optNxt     = optLocked;
    lockoutNxt = lockout || mainMisuse || optMisuse;
    errNxt     = ctrlWr && mainLocked && (|wrData[CTRL_BITS-1:0]);
    if (mainHit) mainNxt = 1'b0;
    if (optHit)  optNxt  = 1'b0;
    if (relockOpt) optNxt = 1'b1;
    if (relockMain) begin
      mainNxt = 1'b1;
      optNxt  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mainLocked <= 1'b1;
      optLocked  <= 1'b1;
      lockout    <= 1'b0;
      accessErr  <= 1'b0;
    end else begin
      mainLocked <= mainNxt;
      optLocked  <= optNxt;
      lockout    <= lockoutNxt;
      accessErr  <= errNxt;
    end
  end

  assign strobe.loadBits = ctrlWr && !mainLocked;
  assign strobe.rdCtrl   = rdEn && isCtrl;
  assign strobe.rdAny    = rdEn;
endmodule

// File: rtl/reg_keylock_dp.sv
module reg_keylock_dp
  import reg_keylock_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  dpStrobe_t            strobe,
  input  logic [CTRL_BITS-1:0] wrBits,
  input  logic                 mainLocked,
  input  logic                 optLocked,
  output logic [CTRL_BITS-1:0] ctrlBits,
  output logic [DATA_W-1:0]    rdData
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlBits <= '0;
      rdData   <= '0;
    end else begin
      if (strobe.loadBits) ctrlBits <= wrBits;
      if (strobe.rdAny)
        rdData <= strobe.rdCtrl ? {mainLocked, optLocked, ctrlBits} : '0;
    end
  end
endmodule

// File: rtl/reg_keylock.sv
module reg_keylock
  import reg_keylock_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] MKEY_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] OKEY_ADDR = 'h2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [CTRL_BITS-1:0] ctrlBits,
  output logic                 mainLocked,
  output logic                 optLocked,
  output logic                 lockout,
  output logic                 accessErr
);
  dpStrobe_t strobe;

  reg_keylock_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .MKEY_ADDR(MKEY_ADDR), .OKEY_ADDR(OKEY_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .wrData    (wrData),
    .mainLocked(mainLocked),
    .optLocked (optLocked),
    .lockout   (lockout),
    .accessErr (accessErr),
    .strobe    (strobe)
  );

  reg_keylock_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .wrBits    (wrData[CTRL_BITS-1:0]),
    .mainLocked(mainLocked),
    .optLocked (optLocked),
    .ctrlBits  (ctrlBits),
    .rdData    (rdData)
  );
endmodule

// File: rtl/reg_keylock_chk.sv
module reg_keylock_chk
  import reg_keylock_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] MKEY_ADDR = 'h1,
  parameter logic [ADDR_W-1:0] OKEY_ADDR = 'h2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wrEn,
  input logic                 rdEn,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wrData,
  input logic [DATA_W-1:0]    rdData,
  input logic [CTRL_BITS-1:0] ctrlBits,
  input logic                 mainLocked,
  input logic                 optLocked,
  input logic                 lockout,
  input logic                 accessErr
);
  assert_main_unlock_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mainLocked) |-> $past(wrEn && addr == MKEY_ADDR && wrData == MAIN_KEY_B));

  assert_opt_unlock_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(optLocked) |-> $past(wrEn && addr == OKEY_ADDR && wrData == OPT_KEY_B && !mainLocked));

  assert_opt_nested_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mainLocked |-> optLocked);

  assert_lockout_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lockout |=> lockout);

  assert_relock_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == CTRL_ADDR && wrData[MAIN_BIT]) |=> (mainLocked && optLocked));

  assert_locked_bits_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == CTRL_ADDR && mainLocked) |=> $stable(ctrlBits));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accessErr |-> $past(wrEn && addr == CTRL_ADDR && mainLocked));

  assert_key_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && addr != CTRL_ADDR) |=> (rdData == '0));
endmodule

bind reg_keylock reg_keylock_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .MKEY_ADDR(MKEY_ADDR), .OKEY_ADDR(OKEY_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .addr      (addr),
  .wrData    (wrData),
  .rdData    (rdData),
  .ctrlBits  (ctrlBits),
  .mainLocked(mainLocked),
  .optLocked (optLocked),
  .lockout   (lockout),
  .accessErr (accessErr)
);

// File: tb/reg_keylock_tb.sv
module reg_keylock_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_MKEY = 4'h1;
  localparam logic [3:0] A_OKEY = 4'h2;
  localparam logic [31:0] MK1 = 32'h4567_0123;
  localparam logic [31:0] MK2 = 32'hCDEF_89AB;
  localparam logic [31:0] OK1 = 32'h0819_2A3B;
  localparam logic [31:0] OK2 = 32'h4C5D_6E7F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [29:0] ctrlBits;
  logic        mainLocked, optLocked, lockout, accessErr;

  int   nChecks = 0;
  int   nFails = 0;
  logic errSeen = 1'b0;
  logic rdPend = 1'b0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  reg_keylock u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ctrlBits(ctrlBits),
    .mainLocked(mainLocked), .optLocked(optLocked),
    .lockout(lockout), .accessErr(accessErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    errSeen = accessErr;
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chkState(input string req, input logic m, input logic o, input logic lo);
    chk(req, "mainLocked", {31'b0, mainLocked}, {31'b0, m});
    chk(req, "optLocked",  {31'b0, optLocked},  {31'b0, o});
    chk(req, "lockout",    {31'b0, lockout},    {31'b0, lo});
  endtask

  // scoreboard monitor: one expected item per read, compared when data appears
  always @(posedge clk) rdPend <= rdEn;
  always @(negedge clk) begin
    if (rdPend) begin
      if (expQ.size() == 0) begin
        chk("R9", "unexpected read", rdData, 32'h0);
      end else begin
        chk(tagQ.pop_front(), "rdData", rdData, expQ.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkState("R1", 1'b1, 1'b1, 1'b0);
    chk("R1", "accessErr", {31'b0, accessErr}, 32'h0);
    chk("R1", "ctrlBits", {2'b0, ctrlBits}, 32'h0);
    rd(A_CTRL, 32'hC000_0000, "R1");

    // R7 locked writes dropped
    wr(A_CTRL, 32'h0000_0005);
    chk("R7", "accessErr", {31'b0, errSeen}, 32'h1);
    chk("R7", "ctrlBits", {2'b0, ctrlBits}, 32'h0);
    wr(A_CTRL, 32'h8000_0000);
    chk("R7", "no err on pure relock", {31'b0, errSeen}, 32'h0);
    chkState("R6", 1'b1, 1'b1, 1'b0);

    // R2 main unlock
    wr(A_MKEY, MK1);
    chkState("R2", 1'b1, 1'b1, 1'b0);
    wr(A_MKEY, MK2);
    chkState("R2", 1'b0, 1'b1, 1'b0);
    rd(A_CTRL, 32'h4000_0000, "R2");

    // R8 unlocked write, R9 key reads
    wr(A_CTRL, 32'h0000_1234);
    chk("R8", "ctrlBits", {2'b0, ctrlBits}, 32'h1234);
    chk("R8", "accessErr", {31'b0, errSeen}, 32'h0);
    rd(A_MKEY, 32'h0, "R9");
    rd(A_OKEY, 32'h0, "R9");
    rd(A_CTRL, 32'h4000_1234, "R9");

    // R3 option unlock
    wr(A_OKEY, OK1);
    chkState("R3", 1'b0, 1'b1, 1'b0);
    wr(A_OKEY, OK2);
    chkState("R3", 1'b0, 1'b0, 1'b0);
    rd(A_CTRL, 32'h0000_1234, "R3");

    // R6 option relock only, zero writes do not clear
    wr(A_CTRL, 32'h4000_1234);
    chkState("R6", 1'b0, 1'b1, 1'b0);
    wr(A_CTRL, 32'h0000_1234);
    chkState("R6", 1'b0, 1'b1, 1'b0);
    wr(A_CTRL, 32'h8000_0077);
    chkState("R6", 1'b1, 1'b1, 1'b0);
    chk("R6", "ctrlBits", {2'b0, ctrlBits}, 32'h77);
    rd(A_CTRL, 32'hC000_0077, "R6");

    // R4 wrong second key, then correct pair is ignored
    wr(A_MKEY, MK1);
    wr(A_MKEY, 32'h1234_5678);
    chkState("R4", 1'b1, 1'b1, 1'b1);
    wr(A_MKEY, MK1);
    wr(A_MKEY, MK2);
    chkState("R4", 1'b1, 1'b1, 1'b1);
    doReset();
    chkState("R1", 1'b1, 1'b1, 1'b0);

    // R4 wrong order
    wr(A_MKEY, MK2);
    chkState("R4", 1'b1, 1'b1, 1'b1);
    doReset();

    // R5 key write while main lock already clear
    wr(A_MKEY, MK1);
    wr(A_MKEY, MK2);
    wr(A_MKEY, MK1);
    chkState("R5", 1'b0, 1'b1, 1'b1);
    doReset();

    // R3 option key while main locked
    wr(A_OKEY, OK1);
    chkState("R3", 1'b1, 1'b1, 1'b1);
    doReset();

    // R5 option key while option lock already clear
    wr(A_MKEY, MK1);
    wr(A_MKEY, MK2);
    wr(A_OKEY, OK1);
    wr(A_OKEY, OK2);
    chkState("R5", 1'b0, 1'b0, 1'b0);
    wr(A_OKEY, OK1);
    chkState("R5", 1'b0, 1'b0, 1'b1);

    repeat (3) @(negedge clk);
    chk("R9", "pending reads", expQ.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule